// File: doc/BRIEF.md
# Execute-Instruction Chain Controller

This block steers instruction fetch for the execute instruction. When the core decodes an execute instruction, the controller redirects the next fetch to that instruction's effective address. The instruction address stays where it was. If the word fetched there is another execute instruction, the controller redirects again. Chains of any depth are followed this way until a non-execute subject instruction arrives.

When the subject completes, the controller sends fetch back to the word after the first execute instruction of the chain. It does not do this if the subject redirected the program itself, as a taken branch or a status-load instruction does.

The controller keeps the address of the first execute instruction of the chain. That address is what gets reported when a trap occurs. It is also where execution restarts when an interrupt is accepted part-way through the chain. The core decodes and executes the subject instruction itself. The controller only supplies fetch redirections, a chain-active flag, the saved address, the address to report, and a restart request.

Top module: `exu_chain_ctrl`

## Requirements
- R1: A decoded execute instruction (`dec_valid`=1, `dec_is_exec`=1) with no trap or interrupt in the same cycle makes `steer_valid`=1 with `steer_addr` equal to its `dec_ea` in the next cycle, and sets `chain_active`.
- R2: An execute instruction decoded while a chain is active redirects to its own effective address, and `saved_addr` keeps the address of the first execute instruction. There is no limit on chain depth.
- R3: `subj_done`=1 with `subj_redirect`=0 while a chain is active gives `steer_valid`=1 and `steer_addr` = `saved_addr`+1 in the next cycle, wrapping modulo 2^ADDR_W. `chain_active` clears.
- R4: `subj_done`=1 with `subj_redirect`=1 while a chain is active clears `chain_active` and leaves `steer_valid`=0.
- R5: `saved_addr` takes `ia_in` when an execute instruction is decoded with no chain active, and holds that value for as long as the chain stays active.
- R6: `intr_take`=1 while a chain is active, with no trap in that cycle, gives a one-cycle `restart_req`=1 in the next cycle and clears `chain_active`. `saved_addr` still holds the first execute instruction's address, which is the restart target.
- R7: While a chain is active, `report_addr` equals `saved_addr`; otherwise it equals `ia_in`. A trap while a chain is active clears `chain_active`, with no steering and no restart.
- R8: A trap or interrupt with no chain active produces no restart, no steering and no chain.
- R9: With `rst_n`=0 at a clock edge, `chain_active`, `steer_valid`, `restart_req` and `saved_addr` are all zero afterwards.
- R10: Within one cycle, trap outranks interrupt, interrupt outranks an execute decode, and an execute decode outranks subject completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ia_in | input | ADDR_W | Address of the instruction the core is currently executing outside a chain |
| dec_valid | input | 1 | A fetched word was decoded this cycle |
| dec_is_exec | input | 1 | The decoded word is an execute instruction |
| dec_ea | input | ADDR_W | Effective address of the decoded word |
| subj_done | input | 1 | Subject instruction completed this cycle |
| subj_redirect | input | 1 | The completing subject changed the program flow itself |
| intr_take | input | 1 | Core accepts an interrupt this cycle |
| trap_take | input | 1 | Core takes a trap this cycle |
| steer_valid | output | 1 | Fetch must come from `steer_addr` |
| steer_addr | output | ADDR_W | Redirected fetch address |
| chain_active | output | 1 | An execute chain is in progress; the instruction address is held |
| saved_addr | output | ADDR_W | Address of the first execute instruction of the chain |
| restart_req | output | 1 | One-cycle request to restart at `saved_addr` after interrupt service |
| report_addr | output | ADDR_W | Address to record on a trap or interrupt |

## Verification
Single execute instructions and chains several deep are each ended in three ways: plain completion, completion with a subject redirect, and an interrupt or trap. This separates resumption at the saved address from a restart and from silent termination. Deep chains with a changing `ia_in` show that the captured address does not follow the instruction address. An all-ones start address shows that resumption wraps. Cycles that combine events exercise the priority order, and interrupts and traps with no chain active show that they have no effect. A stretch of pseudo-random stimulus is then compared against the reference model on every clock.

// File: rtl/exu_chain_pkg.sv
// Shared types for the execute-chain controller.
// Assumes one event is acted on per clock; priority is fixed in exu_chain_seq.
package exu_chain_pkg;

    // Event chosen for the coming clock edge, highest priority first.
    typedef enum logic [2:0] {
        EV_NONE = 3'd0,
        EV_TRAP = 3'd1,
        EV_INTR = 3'd2,
        EV_EXEC = 3'd3,
        EV_DONE = 3'd4
    } chain_ev_e;

endpackage

// File: rtl/exu_chain_seq.sv
// Chain sequencer: ranks the core's events, tracks whether a chain is active
// and raises the restart request after an interrupt inside a chain.
// Assumes all inputs are synchronous to clk and stable around the edge.
module exu_chain_seq
    import exu_chain_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dec_valid,
    input  logic      dec_is_exec,
    input  logic      subj_done,
    input  logic      intr_take,
    input  logic      trap_take,
    output chain_ev_e ev,
    output logic      active_q,
    output logic      restart_q
);

    // Pick the single event for this cycle: trap > interrupt > execute > completion.
    always_comb begin
        if (trap_take)                    ev = EV_TRAP;
        else if (intr_take)               ev = EV_INTR;
        else if (dec_valid && dec_is_exec) ev = EV_EXEC;
        else if (subj_done && active_q)   ev = EV_DONE;
        else                              ev = EV_NONE;
    end

    // Chain-active flag: set by an execute decode, cleared by any chain-ending event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else begin
            case (ev)
                EV_EXEC:                  active_q <= 1'b1;
                EV_TRAP, EV_INTR, EV_DONE: active_q <= 1'b0;
                default:                  active_q <= active_q;
            endcase
        end
    end

    // Restart pulse: only an interrupt inside a running chain asks for a restart.
    always_ff @(posedge clk) begin
        if (!rst_n) restart_q <= 1'b0;
        else        restart_q <= (ev == EV_INTR) && active_q;
    end

    p_intr_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_take && !trap_take && active_q) |=> (restart_q && !active_q));

    p_restart_only_in_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |-> $past(active_q));

    p_trap_ends_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (!active_q && !restart_q));

    p_exec_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_is_exec && !trap_take && !intr_take) |=> active_q);

endmodule

// File: rtl/exu_chain_addr.sv
// Address path: captures the first execute instruction's address, forms the
// fetch redirection and selects the address to report.
// Assumes ev comes from exu_chain_seq and active_q is the current chain flag.
module exu_chain_addr
    import exu_chain_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chain_ev_e         ev,
    input  logic              active_q,
    input  logic [ADDR_W-1:0] ia_in,
    input  logic [ADDR_W-1:0] dec_ea,
    input  logic              subj_redirect,
    output logic [ADDR_W-1:0] saved_q,
    output logic              steer_v_q,
    output logic [ADDR_W-1:0] steer_a_q,
    output logic [ADDR_W-1:0] report_addr
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] resume_addr;

    // Word after the first execute instruction, wrapping at the top of the space.
    always_comb resume_addr = saved_q + ONE;

    // Saved address: loaded only when a chain begins, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                        saved_q <= '0;
        else if (ev == EV_EXEC && !active_q) saved_q <= ia_in;
    end

    // Fetch redirection: to the effective address, or back after the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steer_v_q <= 1'b0;
            steer_a_q <= '0;
        end else if (ev == EV_EXEC) begin
            steer_v_q <= 1'b1;
            steer_a_q <= dec_ea;
        end else if (ev == EV_DONE && !subj_redirect) begin
            steer_v_q <= 1'b1;
            steer_a_q <= resume_addr;
        end else begin
            steer_v_q <= 1'b0;
        end
    end

    // Reported address: the chain's first instruction while a chain runs.
    always_comb report_addr = active_q ? saved_q : ia_in;

    p_saved_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |=> $stable(saved_q));

    p_resume_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_DONE && !subj_redirect) |=> (steer_v_q && steer_a_q == $past(resume_addr)));

    p_redirect_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_DONE && subj_redirect) |=> !steer_v_q);

    p_exec_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_EXEC) |=> (steer_v_q && steer_a_q == $past(dec_ea)));

endmodule

// File: rtl/exu_chain_ctrl.sv
// Top of the execute-chain controller: joins the event sequencer and the
// address path. Assumes the core holds its instruction address while
// chain_active is high and fetches from steer_addr when steer_valid is high.
module exu_chain_ctrl #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ia_in,
    input  logic              dec_valid,
    input  logic              dec_is_exec,
    input  logic [ADDR_W-1:0] dec_ea,
    input  logic              subj_done,
    input  logic              subj_redirect,
    input  logic              intr_take,
    input  logic              trap_take,
    output logic              steer_valid,
    output logic [ADDR_W-1:0] steer_addr,
    output logic              chain_active,
    output logic [ADDR_W-1:0] saved_addr,
    output logic              restart_req,
    output logic [ADDR_W-1:0] report_addr
);
    import exu_chain_pkg::*;

    chain_ev_e ev;

    exu_chain_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_valid   (dec_valid),
        .dec_is_exec (dec_is_exec),
        .subj_done   (subj_done),
        .intr_take   (intr_take),
        .trap_take   (trap_take),
        .ev          (ev),
        .active_q    (chain_active),
        .restart_q   (restart_req)
    );

    exu_chain_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev            (ev),
        .active_q      (chain_active),
        .ia_in         (ia_in),
        .dec_ea        (dec_ea),
        .subj_redirect (subj_redirect),
        .saved_q       (saved_addr),
        .steer_v_q     (steer_valid),
        .steer_a_q     (steer_addr),
        .report_addr   (report_addr)
    );

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (!chain_active && !steer_valid && !restart_req && saved_addr == '0));

endmodule

// File: tb/exu_chain_ctrl_tb.sv
module exu_chain_ctrl_tb;
    localparam int AW = 17;
    localparam int CLK_PERIOD = 10;
    localparam int MASK = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] ia_in = '0, dec_ea = '0;
    logic dec_valid = 0, dec_is_exec = 0, subj_done = 0, subj_redirect = 0;
    logic intr_take = 0, trap_take = 0;
    logic steer_valid, chain_active, restart_req;
    logic [AW-1:0] steer_addr, saved_addr, report_addr;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // behavioural reference state
    int m_act = 0, m_saved = 0, m_sv = 0, m_sa = 0, m_rst = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exu_chain_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ia_in(ia_in), .dec_valid(dec_valid),
        .dec_is_exec(dec_is_exec), .dec_ea(dec_ea), .subj_done(subj_done),
        .subj_redirect(subj_redirect), .intr_take(intr_take), .trap_take(trap_take),
        .steer_valid(steer_valid), .steer_addr(steer_addr), .chain_active(chain_active),
        .saved_addr(saved_addr), .restart_req(restart_req), .report_addr(report_addr));

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every output with the model.
    task automatic cmp_all();
        chk("R1", "steer_valid", int'(steer_valid), m_sv);
        if (m_sv != 0) chk("R3", "steer_addr", int'(steer_addr), m_sa);
        chk("R7", "chain_active", int'(chain_active), m_act);
        chk("R5", "saved_addr", int'(saved_addr), m_saved);
        chk("R6", "restart_req", int'(restart_req), m_rst);
        chk("R7", "report_addr", int'(report_addr), m_act != 0 ? m_saved : int'(ia_in));
    endtask

    // One clock: drive inputs, predict, then compare after the edge.
    task automatic cyc(bit rn, bit dv, bit ex, int ea, bit dn, bit rd, bit it, bit tr, int ia);
        int n_act, n_saved, n_sv, n_sa, n_rst;
        @(negedge clk);
        rst_n = rn; dec_valid = dv; dec_is_exec = ex; dec_ea = AW'(ea);
        subj_done = dn; subj_redirect = rd; intr_take = it; trap_take = tr; ia_in = AW'(ia);
        n_act = m_act; n_saved = m_saved; n_sv = 0; n_sa = m_sa; n_rst = 0;
        if (!rn) begin
            n_act = 0; n_saved = 0; n_sv = 0; n_sa = 0;
        end else if (tr) begin
            n_act = 0;
        end else if (it) begin
            n_rst = m_act; n_act = 0;
        end else if (dv && ex) begin
            if (m_act == 0) n_saved = ia & MASK;
            n_act = 1; n_sv = 1; n_sa = ea & MASK;
        end else if (dn && m_act != 0) begin
            n_act = 0;
            if (!rd) begin n_sv = 1; n_sa = (m_saved + 1) & MASK; end
        end
        @(posedge clk); #1;
        m_act = n_act; m_saved = n_saved; m_sv = n_sv; m_sa = n_sa; m_rst = n_rst;
        cmp_all();
    endtask

    task automatic idle(int ia); cyc(1,0,0,0,0,0,0,0,ia); endtask
    task automatic exu(int ea, int ia); cyc(1,1,1,ea,0,0,0,0,ia); endtask
    task automatic subj(int ia); cyc(1,1,0,0,0,0,0,0,ia); endtask
    task automatic done(bit rd, int ia); cyc(1,0,0,0,1,rd,0,0,ia); endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        cyc(0,1,1,5,0,0,0,0,7);
        cyc(0,0,0,0,0,0,0,0,7);
        chk("R9", "active after reset", int'(chain_active), 0);
        chk("R9", "saved after reset", int'(saved_addr), 0);
        idle(16);

        // R1 single execute, then R3 resume after it
        exu('h200, 'h100);
        chk("R1", "steer to ea", int'(steer_addr), 'h200);
        subj('h100);
        done(0, 'h100);
        chk("R3", "resume address", int'(steer_addr), 'h101);
        chk("R3", "chain cleared", int'(chain_active), 0);

        // R2 deep chain with changing ia_in
        exu('h400, 'h300);
        for (int i = 1; i < 8; i++) exu('h400 + i, 'h300 + 3*i);
        chk("R2", "saved after deep chain", int'(saved_addr), 'h300);
        chk("R2", "steer follows last", int'(steer_addr), 'h407);
        subj('h555);
        done(0, 'h555);
        chk("R3", "resume after deep chain", int'(steer_addr), 'h301);

        // R4 subject redirects itself
        exu('h20, 'h10); exu('h30, 'h11); subj('h12);
        done(1, 'h12);
        chk("R4", "no steer on redirect", int'(steer_valid), 0);
        chk("R4", "chain cleared", int'(chain_active), 0);

        // R6 interrupt mid chain
        exu('h900, 'h800); exu('h910, 'h801);
        cyc(1,0,0,0,0,0,1,0,'h802);
        chk("R6", "restart pulse", int'(restart_req), 1);
        chk("R6", "restart target", int'(saved_addr), 'h800);
        idle('h802);
        chk("R6", "pulse one cycle", int'(restart_req), 0);

        // R7 trap mid chain; report address during chain
        exu('h1000, 'h0fff); exu('h1100, 'h0aaa);
        chk("R7", "report first exec", int'(report_addr), 'h0fff);
        cyc(1,0,0,0,0,0,0,1,'h0aaa);
        chk("R7", "trap clears", int'(chain_active), 0);
        chk("R7", "trap no restart", int'(restart_req), 0);

        // R8 events outside a chain
        cyc(1,0,0,0,0,0,1,0,'h77);
        chk("R8", "intr idle no restart", int'(restart_req), 0);
        cyc(1,0,0,0,0,0,0,1,'h78);
        chk("R8", "trap idle no chain", int'(chain_active), 0);
        cyc(1,0,0,0,1,0,0,0,'h79);
        chk("R8", "done idle no steer", int'(steer_valid), 0);

        // R10 priorities
        cyc(1,1,1,'h50,0,0,0,1,'h40);
        chk("R10", "trap beats exec", int'(chain_active), 0);
        cyc(1,1,1,'h50,0,0,1,0,'h40);
        chk("R10", "intr beats exec", int'(steer_valid), 0);
        exu('h60, 'h41);
        cyc(1,1,1,'h70,1,0,0,0,'h42);
        chk("R10", "exec beats done", int'(steer_addr), 'h70);
        cyc(1,0,0,0,1,0,1,1,'h42);
        chk("R10", "trap beats intr", int'(restart_req), 0);

        // R3 wrap of resume address
        exu('h5, MASK); subj(3); done(0, 3);
        chk("R3", "resume wraps", int'(steer_addr), 0);

        // R9 reset mid chain
        exu('h123, 'h321);
        cyc(0,0,0,0,0,0,0,0,'h321);
        chk("R9", "reset mid chain", int'(chain_active), 0);

        // pseudo-random stretch against the model
        for (int k = 0; k < 400; k++) begin
            int r = $urandom;
            cyc(1, r[0] | r[1], r[2] | r[3], $urandom & MASK, r[4] & r[5], r[6],
                (r[7:10] == 0), (r[11:14] == 0), $urandom & MASK);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule